// File: doc/BRIEF.md
# Flow-Control Command Transmit Controller

This block sits between a software command bit and the transmit side of an Ethernet MAC. Software, or an enabled external flow-control pin, produces rising and falling edges. The block reads each edge in light of the link's duplex mode and a fixed-length pause mode. In half duplex an edge switches a back-pressure enable on or off. In full duplex an edge becomes a request to the transmitter for a pause frame, and the block supplies the 16-bit operand for that frame.

There are two full-duplex styles. With fixed-length mode on, a rising edge asks for one pause frame whose operand is the programmed pause length. The command bit then drops back to 0 by itself, and that drop sends nothing. With fixed-length mode off, a rising edge asks for the largest possible pause (stop) and a falling edge asks for a zero pause (resume).

A request stays raised until the MAC acknowledges that the frame has been sent. The raised request doubles as the pending flag that software polls before it rewrites the pause length. The operand is captured when the request is made. If a newer request arrives before the acknowledge, it takes the place of the older one.

Top module: `fc_cmd_tx`

## Requirements
- R1: After reset, txReq, backPressure and cmdBit are 0 and txOperand is 0x0000.
- R2: With fullDuplex low, a 0-to-1 edge sets backPressure after the next clock and a 1-to-0 edge clears it. The fixed-length mode has no effect on this, and no pause request is raised.
- R3: With fullDuplex high and fixed-length mode on, a 0-to-1 command write raises txReq with txOperand equal to the pause length register. cmdBit reads 1 for one cycle and then returns to 0 without any further write.
- R4: With fullDuplex high and fixed-length mode on, a 1-to-0 edge never raises a request. This covers both the self-clear and a software write of 0.
- R5: With fullDuplex high and fixed-length mode off, a 0-to-1 edge requests a pause with operand 0xFFFF.
- R6: With fullDuplex high and fixed-length mode off, a 1-to-0 edge requests a pause with operand 0x0000.
- R7: txReq (the pending flag) rises on the clock after a request. It stays high until a cycle with txAck high and falls on the following clock. txAck while txReq is low does nothing.
- R8: txOperand is captured when the request is made. Writes to the pause length register that come after it leave txOperand unchanged.
- R9: A request that arrives while one is pending replaces txOperand. If it coincides with txAck, txReq stays high.
- R10: While the pin enable is set, the fcPin input passes through SYNC_STAGES synchronizer flops and one edge-detect flop. A rising edge on fcPin then acts like a 0-to-1 command edge and a falling edge acts like a 1-to-0 command edge. While the enable is clear, fcPin has no effect.
- R11: If a rising edge and a falling edge, from the command and the pin, are decoded in the same cycle, the rising edge wins.
- R12: backPressure reads 0 whenever fullDuplex is high. The stored enable is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWrEn | input | 1 | Write strobe for the command bit |
| cmdWrData | input | 1 | New value of the command bit |
| ctlWrEn | input | 1 | Write strobe for the mode bits |
| ctlFixedPause | input | 1 | Fixed-length pause mode value |
| ctlPinEn | input | 1 | External pin enable value |
| lenWrEn | input | 1 | Write strobe for the pause length register |
| lenWrData | input | OP_W | New pause length |
| fullDuplex | input | 1 | Link duplex: 1 full, 0 half |
| fcPin | input | 1 | Asynchronous external flow-control pin |
| txAck | input | 1 | MAC has sent the requested pause frame |
| cmdBit | output | 1 | Current command bit value |
| txReq | output | 1 | Pause frame requested; also the pending flag |
| txOperand | output | OP_W | Request operand for the pause frame |
| backPressure | output | 1 | Half-duplex back-pressure enable |

## Verification
The bench builds the block with its defaults: a 16-bit operand and two synchronizer stages. The 16-bit width makes the 0xFFFF stop and 0x0000 resume operands directly observable. The two-stage synchronizer keeps the pin-to-request latency at three clocks, so the pin rising edge can be timed to land in the same cycle as a command falling write. A bench model tracks the command bit, the synchronized pin, back pressure and the pending request every clock, while random writes, acknowledges, duplex changes and pin toggles run against it.

// File: rtl/fc_cmd_pkg.sv
package fc_cmd_pkg;

  // Which value the datapath captures as the pause operand
  typedef enum logic [1:0] {
    OP_LEN  = 2'd0,
    OP_MAX  = 2'd1,
    OP_ZERO = 2'd2
  } opSel_e;

  // Strobes from the edge decoder to the datapath
  typedef struct packed {
    logic   loadOp;
    opSel_e opSel;
    logic   setBp;
    logic   clrBp;
  } fcStrb_t;

endpackage

// File: rtl/fc_cmd_ctrl.sv
module fc_cmd_ctrl
  import fc_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdWrEn,
  input  logic    cmdWrData,
  input  logic    ctlWrEn,
  input  logic    ctlFixedPause,
  input  logic    ctlPinEn,
  input  logic    fullDuplex,
  input  logic    fcPin,
  output logic    cmdBit,
  output logic    fixedMode,
  output fcStrb_t strb
);

  logic                   cmdQ;
  logic                   fixedQ;
  logic                   pinEnQ;
  logic                   pinPrev;
  logic [SYNC_STAGES-1:0] pinSync;
  logic                   pinLvl;

  // Pin synchronizer: depth picked by parameter
  generate
    if (SYNC_STAGES == 1) begin : g_oneStage
      always_ff @(posedge clk) begin
        if (!rstN) pinSync <= '0;
        else       pinSync <= fcPin;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rstN) pinSync <= '0;
        else       pinSync <= {pinSync[SYNC_STAGES-2:0], fcPin};
      end
    end
  endgenerate

  assign pinLvl = pinSync[SYNC_STAGES-1];

  logic selfClr;
  assign selfClr = cmdQ & fullDuplex & fixedQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ    <= 1'b0;
      fixedQ  <= 1'b0;
      pinEnQ  <= 1'b0;
      pinPrev <= 1'b0;
    end else begin
      pinPrev <= pinLvl;
      if (cmdWrEn)      cmdQ <= cmdWrData;
      else if (selfClr) cmdQ <= 1'b0;
      if (ctlWrEn) begin
        fixedQ <= ctlFixedPause;
        pinEnQ <= ctlPinEn;
      end
    end
  end

  logic cmdRise, cmdFall, pinRise, pinFall, riseEv, fallEv;

  always_comb begin
    cmdRise = cmdWrEn & cmdWrData & ~cmdQ;
    cmdFall = cmdWrEn & ~cmdWrData & cmdQ;
    pinRise = pinEnQ & pinLvl & ~pinPrev;
    pinFall = pinEnQ & ~pinLvl & pinPrev;
    riseEv  = cmdRise | pinRise;
    fallEv  = (cmdFall | pinFall) & ~riseEv;

    strb = '{loadOp: 1'b0, opSel: OP_ZERO, setBp: 1'b0, clrBp: 1'b0};
    if (!fullDuplex) begin
      strb.setBp = riseEv;
      strb.clrBp = fallEv;
    end else if (fixedQ) begin
      strb.loadOp = riseEv;
      strb.opSel  = OP_LEN;
    end else begin
      strb.loadOp = riseEv | fallEv;
      strb.opSel  = riseEv ? OP_MAX : OP_ZERO;
    end
  end

  assign cmdBit    = cmdQ;
  assign fixedMode = fixedQ;

endmodule

// File: rtl/fc_cmd_dp.sv
module fc_cmd_dp
  import fc_cmd_pkg::*;
#(
  parameter int OP_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  fcStrb_t         strb,
  input  logic            lenWrEn,
  input  logic [OP_W-1:0] lenWrData,
  input  logic            txAck,
  input  logic            fullDuplex,
  output logic            txReq,
  output logic [OP_W-1:0] txOperand,
  output logic            backPressure
);

  localparam logic [OP_W-1:0] OP_MAX_VAL  = '1;
  localparam logic [OP_W-1:0] OP_ZERO_VAL = '0;

  logic [OP_W-1:0] lenQ;
  logic [OP_W-1:0] opQ;
  logic [OP_W-1:0] opNext;
  logic            reqQ;
  logic            bpQ;

  always_comb begin
    case (strb.opSel)
      OP_LEN:  opNext = lenQ;
      OP_MAX:  opNext = OP_MAX_VAL;
      default: opNext = OP_ZERO_VAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenQ <= '0;
      opQ  <= '0;
      reqQ <= 1'b0;
      bpQ  <= 1'b0;
    end else begin
      if (lenWrEn) lenQ <= lenWrData;
      if (strb.loadOp) begin
        opQ  <= opNext;
        reqQ <= 1'b1;
      end else if (txAck) begin
        reqQ <= 1'b0;
      end
      if (strb.setBp)      bpQ <= 1'b1;
      else if (strb.clrBp) bpQ <= 1'b0;
    end
  end

  assign txReq        = reqQ;
  assign txOperand    = opQ;
  assign backPressure = bpQ & ~fullDuplex;

endmodule

// File: rtl/fc_cmd_tx.sv
module fc_cmd_tx
  import fc_cmd_pkg::*;
#(
  parameter int OP_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdWrEn,
  input  logic            cmdWrData,
  input  logic            ctlWrEn,
  input  logic            ctlFixedPause,
  input  logic            ctlPinEn,
  input  logic            lenWrEn,
  input  logic [OP_W-1:0] lenWrData,
  input  logic            fullDuplex,
  input  logic            fcPin,
  input  logic            txAck,
  output logic            cmdBit,
  output logic            txReq,
  output logic [OP_W-1:0] txOperand,
  output logic            backPressure
);

  fcStrb_t strb;
  logic    fixedMode;
  logic    loadOp;

  assign loadOp = strb.loadOp;

  fc_cmd_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData),
    .ctlWrEn(ctlWrEn), .ctlFixedPause(ctlFixedPause), .ctlPinEn(ctlPinEn),
    .fullDuplex(fullDuplex), .fcPin(fcPin),
    .cmdBit(cmdBit), .fixedMode(fixedMode), .strb(strb)
  );

  fc_cmd_dp #(.OP_W(OP_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .lenWrEn(lenWrEn), .lenWrData(lenWrData),
    .txAck(txAck), .fullDuplex(fullDuplex),
    .txReq(txReq), .txOperand(txOperand), .backPressure(backPressure)
  );

endmodule

// File: rtl/fc_cmd_tx_chk.sv
module fc_cmd_tx_chk #(
  parameter int OP_W = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic            cmdWrEn,
  input logic            fullDuplex,
  input logic            txAck,
  input logic            txReq,
  input logic [OP_W-1:0] txOperand,
  input logic            cmdBit,
  input logic            fixedMode,
  input logic            loadOp
);

  // R7: a raised request holds until acknowledged
  a_r7_req_holds: assert property (@(posedge clk) disable iff (!rstN)
    txReq && !txAck |=> txReq);

  // R7: acknowledge without a new request drops the request
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    txReq && txAck && !loadOp |=> !txReq);

  // R8: operand changes only when a request captures it
  a_r8_op_stable: assert property (@(posedge clk) disable iff (!rstN)
    !loadOp |=> $stable(txOperand));

  // R9: a decoded request always leaves the request raised
  a_r9_load_sets: assert property (@(posedge clk) disable iff (!rstN)
    loadOp |=> txReq);

  // R2: half duplex never asks for a pause frame
  a_r2_no_req_half: assert property (@(posedge clk) disable iff (!rstN)
    !fullDuplex |-> !loadOp);

  // R3: command bit self-clears in full-duplex fixed-length mode
  a_r3_self_clear: assert property (@(posedge clk) disable iff (!rstN)
    cmdBit && !cmdWrEn && fullDuplex && fixedMode |=> !cmdBit);

endmodule

bind fc_cmd_tx fc_cmd_tx_chk #(.OP_W(OP_W)) chk_i (
  .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .fullDuplex(fullDuplex),
  .txAck(txAck), .txReq(txReq), .txOperand(txOperand), .cmdBit(cmdBit),
  .fixedMode(fixedMode), .loadOp(loadOp)
);

// File: tb/fc_cmd_tx_tb.sv
`timescale 1ns/1ps
module fc_cmd_tx_tb_top;

  localparam int OP_W = 16;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdWrEn = 0, cmdWrData = 0, ctlWrEn = 0, ctlFixedPause = 0, ctlPinEn = 0;
  logic lenWrEn = 0, fullDuplex = 0, fcPin = 0, txAck = 0;
  logic [OP_W-1:0] lenWrData = '0;
  logic cmdBit, txReq, backPressure;
  logic [OP_W-1:0] txOperand;

  always #4 clk = ~clk;

  fc_cmd_tx #(.OP_W(OP_W), .SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData),
    .ctlWrEn(ctlWrEn), .ctlFixedPause(ctlFixedPause), .ctlPinEn(ctlPinEn),
    .lenWrEn(lenWrEn), .lenWrData(lenWrData), .fullDuplex(fullDuplex),
    .fcPin(fcPin), .txAck(txAck), .cmdBit(cmdBit), .txReq(txReq),
    .txOperand(txOperand), .backPressure(backPressure)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // Bench model of the requirements
  logic mCmd = 0, mBp = 0, mReq = 0, mFixed = 0, mPinEn = 0, mPrev = 0;
  logic [SYNC-1:0] mSync = '0;
  logic [OP_W-1:0] mOp = '0, mLen = '0;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [OP_W-1:0] opFor(logic rise, logic fixed, logic [OP_W-1:0] len);
    if (fixed) return len;
    return rise ? '1 : '0;
  endfunction

  task automatic modelEdge();
    logic pl, cRise, cFall, pRise, pFall, rise, fall, ld;
    logic [OP_W-1:0] nOp;
    pl    = mSync[SYNC-1];
    cRise = cmdWrEn && cmdWrData && !mCmd;
    cFall = cmdWrEn && !cmdWrData && mCmd;
    pRise = mPinEn && pl && !mPrev;
    pFall = mPinEn && !pl && mPrev;
    rise  = cRise || pRise;
    fall  = (cFall || pFall) && !rise;
    ld    = 0;
    nOp   = mOp;
    if (!fullDuplex) begin
      if (rise) mBp = 1; else if (fall) mBp = 0;
    end else if (mFixed) begin
      if (rise) begin ld = 1; nOp = opFor(1, 1, mLen); end
    end else if (rise || fall) begin
      ld = 1; nOp = opFor(rise, 0, mLen);
    end
    if (ld) begin mReq = 1; mOp = nOp; end
    else if (txAck) mReq = 0;
    if (cmdWrEn) mCmd = cmdWrData;
    else if (mCmd && fullDuplex && mFixed) mCmd = 0;
    if (lenWrEn) mLen = lenWrData;
    if (ctlWrEn) begin mFixed = ctlFixedPause; mPinEn = ctlPinEn; end
    mPrev = pl;
    mSync = {mSync[SYNC-2:0], fcPin};
  endtask

  task automatic compareAll();
    check(txReq === mReq, "R7 txReq", txReq, mReq);
    check(txOperand === mOp, "R8 txOperand", txOperand, mOp);
    check(backPressure === (mBp && !fullDuplex), "R2 backPressure", backPressure, mBp && !fullDuplex);
    check(cmdBit === mCmd, "R3 cmdBit", cmdBit, mCmd);
  endtask

  task automatic idle();
    cmdWrEn = 0; ctlWrEn = 0; lenWrEn = 0; txAck = 0;
  endtask

  task automatic step();
    @(posedge clk);
    modelEdge();
    #1;
    compareAll();
    idle();
  endtask

  task automatic wrCmd(logic v);  cmdWrEn = 1; cmdWrData = v; step(); endtask
  task automatic wrCtl(logic fx, logic pe); ctlWrEn = 1; ctlFixedPause = fx; ctlPinEn = pe; step(); endtask
  task automatic wrLen(logic [OP_W-1:0] v); lenWrEn = 1; lenWrData = v; step(); endtask
  task automatic ack(); txAck = 1; step(); endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    // R1: reset state
    check(txReq === 0 && backPressure === 0 && cmdBit === 0, "R1 flags", {txReq, backPressure, cmdBit}, 0);
    check(txOperand === '0, "R1 operand", txOperand, 0);

    // R2: half duplex back pressure, fixed mode irrelevant
    fullDuplex = 0;
    wrCtl(1, 0);
    wrCmd(1);
    check(backPressure === 1 && txReq === 0, "R2 set", {backPressure, txReq}, 2'b10);
    // R12: hidden in full duplex, kept underneath
    fullDuplex = 1; #1;
    check(backPressure === 0, "R12 full duplex hides", backPressure, 0);
    fullDuplex = 0; #1;
    check(backPressure === 1, "R12 kept", backPressure, 1);
    wrCmd(0);
    check(backPressure === 0 && txReq === 0, "R2 clear", {backPressure, txReq}, 0);

    // R3/R4: fixed-length pause
    fullDuplex = 1;
    wrLen(16'h1234);
    wrCmd(1);
    check(txReq === 1 && txOperand === 16'h1234, "R3 fixed operand", txOperand, 16'h1234);
    check(cmdBit === 1, "R3 cmd reads one", cmdBit, 1);
    step();
    check(cmdBit === 0, "R3 self clear", cmdBit, 0);
    check(txReq === 1 && txOperand === 16'h1234, "R4 no request on self clear", txOperand, 16'h1234);
    ack();
    check(txReq === 0, "R7 ack clears", txReq, 0);
    step();
    check(txReq === 0, "R4 still idle", txReq, 0);
    ack();
    check(txReq === 0, "R7 idle ack ignored", txReq, 0);

    // R8: operand captured at request
    wrCmd(1);
    wrLen(16'hBEEF);
    check(txOperand === 16'h1234, "R8 captured operand", txOperand, 16'h1234);
    ack();

    // R5/R6: stop / resume pair
    wrCtl(0, 0);
    wrCmd(1);
    check(txReq === 1 && txOperand === 16'hFFFF, "R5 stop operand", txOperand, 16'hFFFF);
    ack();
    wrCmd(0);
    check(txReq === 1 && txOperand === 16'h0000, "R6 resume operand", txOperand, 16'h0000);
    ack();

    // R9: replacement with simultaneous ack
    wrCmd(1);
    cmdWrEn = 1; cmdWrData = 0; txAck = 1; step();
    check(txReq === 1 && txOperand === 16'h0000, "R9 replace on ack", txOperand, 16'h0000);
    ack();

    // R10: enabled pin
    wrCtl(0, 1);
    fcPin = 1;
    step(); step();
    check(txReq === 0, "R10 sync latency", txReq, 0);
    step();
    check(txReq === 1 && txOperand === 16'hFFFF, "R10 pin rise", txOperand, 16'hFFFF);
    ack();
    fcPin = 0;
    step(); step(); step();
    check(txReq === 1 && txOperand === 16'h0000, "R10 pin fall", txOperand, 16'h0000);
    ack();
    // R10: disabled pin ignored
    wrCtl(0, 0);
    fcPin = 1;
    repeat (5) step();
    check(txReq === 0, "R10 pin disabled", txReq, 0);
    fcPin = 0;
    repeat (5) step();

    // R11: rise from pin and fall from command in one cycle
    wrCmd(1);
    ack();
    wrCtl(0, 1);
    fcPin = 1;
    step(); step();
    cmdWrEn = 1; cmdWrData = 0; step();
    check(txReq === 1 && txOperand === 16'hFFFF, "R11 rise wins", txOperand, 16'hFFFF);
    ack();

    // Random phase against the model
    for (int i = 0; i < 4000; i++) begin
      cmdWrEn   = ($urandom % 4) == 0;
      cmdWrData = $urandom % 2;
      lenWrEn   = ($urandom % 8) == 0;
      lenWrData = $urandom;
      ctlWrEn   = ($urandom % 16) == 0;
      ctlFixedPause = $urandom % 2;
      ctlPinEn  = $urandom % 2;
      txAck     = ($urandom % 3) == 0;
      if (($urandom % 32) == 0) fullDuplex = ~fullDuplex;
      if (($urandom % 6) == 0) fcPin = ~fcPin;
      #1;
      check(backPressure === (mBp && !fullDuplex), "R12 comb", backPressure, mBp && !fullDuplex);
      step();
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule